// File: doc/BRIEF.md
# Roving Test Region Sequencer

This controller moves two test regions across a square array of N by N logic tiles while the rest of the array keeps running. The vertical region is two tile columns wide and travels sideways; the horizontal region is two tile rows high and travels up and down. Both regions move together, two tiles per step. When a region reaches the far edge of the array it turns and travels back, so the regions rove back and forth without end.

A step starts when the run input is high and the controller is idle. The controller moves both regions to their next index and raises a one-cycle relocate strobe. It then waits until the reconfiguration agent reports that the step is done. A position already known to be faulty can be passed over with the skip input. The regions then advance with no strobe and no wait, and the next step may follow at once. A sweep-done pulse marks each turn at an edge.

Top module: `rove_seq`

## Requirements
- R1: After reset the vertical region is at column 0 and the horizontal region is at row 0. Both move forward (back flags 0 = rightward and downward). Relocate, sweep-done and busy are all low.
- R2: Each accepted step moves both regions by exactly two tiles in their current direction. The column index and the row index are always equal.
- R3: A step taken without skip raises relocate_o for exactly one cycle. It is raised in the cycle after the step is accepted, and the new positions are already on the outputs in that cycle.
- R4: After a relocate, busy_o stays high and the positions stay frozen until ack_i is seen, whatever run_i does.
- R5: ack_i has no effect while the controller is idle. Positions, strobe and busy stay unchanged.
- R6: A region that steps onto index N-2 while moving forward turns to move backward. A region that steps onto index 0 while moving backward turns to move forward.
- R7: sweep_done_o pulses for one cycle, together with the new positions, on every step that causes a turn, and on no other step.
- R8: A step taken with skip_i high updates the positions, raises no relocate and leaves the controller idle. A further step can be accepted on the next clock edge.
- R9: Positions are always even and never exceed N-2.
- R10: Starting from reset, N-2 unskipped steps bring both regions back to index 0, moving forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Request the next roving step |
| skip_i | input | 1 | Pass over the next position without relocating |
| ack_i | input | 1 | Step done, from the reconfiguration agent |
| v_col_o | output | $clog2(N_TILES) | First column of the vertical region |
| h_row_o | output | $clog2(N_TILES) | First row of the horizontal region |
| v_back_o | output | 1 | Vertical region moving leftward |
| h_back_o | output | 1 | Horizontal region moving upward |
| relocate_o | output | 1 | One-cycle relocate strobe |
| sweep_done_o | output | 1 | One-cycle pulse on a direction turn |
| busy_o | output | 1 | Waiting for step-done |

## Verification
A step accepted at clock edge k shows its new positions, directions, relocate strobe and sweep-done pulse right after edge k. All of these are registered one stage deep. busy_o rises on that same edge and falls on the edge that samples ack_i. The bench drives inputs on falling edges and samples one falling edge after each stimulus edge, so every check lands in the first cycle the result is due. A reference model in the bench tracks position and direction.

// File: rtl/rove_pkg.sv
package rove_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rove_state_e;
endpackage

// File: rtl/rove_axis.sv
module rove_axis #(
  parameter int N_TILES = 8,
  localparam int IDX_W = $clog2(N_TILES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [IDX_W-1:0] pos_o,
  output logic             back_o,
  output logic             turn_o
);
  localparam logic [IDX_W:0] LAST = (IDX_W+1)'(N_TILES - 2);

  logic [IDX_W:0] pos_q, pos_nxt;
  logic           back_q, turn_q, turn_nxt;

  always_comb begin
    pos_nxt  = back_q ? pos_q - (IDX_W+1)'(2) : pos_q + (IDX_W+1)'(2);
    turn_nxt = back_q ? (pos_nxt == '0) : (pos_nxt == LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      back_q <= 1'b0;
      turn_q <= 1'b0;
    end else begin
      turn_q <= advance_i && turn_nxt;
      if (advance_i) begin
        pos_q <= pos_nxt;
        if (turn_nxt) back_q <= ~back_q;
      end
    end
  end

  assign pos_o  = pos_q[IDX_W-1:0];
  assign back_o = back_q;
  assign turn_o = turn_q;

  p_pos_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q[0] == 1'b0) && (pos_q <= LAST));

  p_step_two_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |=> ((pos_q == $past(pos_q) + (IDX_W+1)'(2)) ||
                   (pos_q + (IDX_W+1)'(2) == $past(pos_q))));

  p_turn_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_q |-> ((pos_q == '0 && !back_q) || (pos_q == LAST && back_q)));

  p_turn_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |=> !turn_q);
endmodule

// File: rtl/rove_step_fsm.sv
module rove_step_fsm
  import rove_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic skip_i,
  input  logic ack_i,
  output logic advance_o,
  output logic relocate_o,
  output logic busy_o
);
  rove_state_e state_q, state_d;
  logic        reloc_q;

  assign advance_o = (state_q == ST_IDLE) && run_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (run_i && !skip_i) state_d = ST_WAIT;
      ST_WAIT: if (ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      reloc_q <= 1'b0;
    end else begin
      state_q <= state_d;
      reloc_q <= advance_o && !skip_i;
    end
  end

  assign relocate_o = reloc_q;
  assign busy_o     = (state_q == ST_WAIT);

  p_reloc_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relocate_o |=> !relocate_o);

  p_reloc_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relocate_o |-> busy_o);

  p_skip_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_o && skip_i) |=> (!relocate_o && !busy_o));

  p_wait_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ack_i) |=> busy_o);
endmodule

// File: rtl/rove_seq.sv
module rove_seq #(
  parameter int N_TILES = 8,
  localparam int IDX_W = $clog2(N_TILES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             skip_i,
  input  logic             ack_i,
  output logic [IDX_W-1:0] v_col_o,
  output logic [IDX_W-1:0] h_row_o,
  output logic             v_back_o,
  output logic             h_back_o,
  output logic             relocate_o,
  output logic             sweep_done_o,
  output logic             busy_o
);
  localparam int N_AXES = 2;

  logic                   advance;
  logic [IDX_W-1:0]       pos   [N_AXES];
  logic [N_AXES-1:0]      back, turn;

  rove_step_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .skip_i     (skip_i),
    .ack_i      (ack_i),
    .advance_o  (advance),
    .relocate_o (relocate_o),
    .busy_o     (busy_o)
  );

  // axis 0 = vertical region (columns), axis 1 = horizontal region (rows)
  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    rove_axis #(.N_TILES(N_TILES)) u_axis (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .advance_i (advance),
      .pos_o     (pos[a]),
      .back_o    (back[a]),
      .turn_o    (turn[a])
    );
  end

  assign v_col_o      = pos[0];
  assign h_row_o      = pos[1];
  assign v_back_o     = back[0];
  assign h_back_o     = back[1];
  assign sweep_done_o = |turn;

  initial begin
    a_even_tiles: assert (N_TILES >= 4 && N_TILES % 2 == 0);
  end

  p_lockstep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_col_o == h_row_o) && (v_back_o == h_back_o));

  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(v_col_o) && $stable(h_row_o)));

  p_idle_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !run_i) |=> ($stable(v_col_o) && !relocate_o && !busy_o));
endmodule

// File: tb/rove_seq_tb_top.sv
module rove_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, skip = 1'b0, ack = 1'b0;
  logic [W-1:0] v_col, h_row;
  logic v_back, h_back, reloc, sweep, busy;

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_pos = 0;
  bit exp_back = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rove_seq #(.N_TILES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .skip_i(skip), .ack_i(ack),
    .v_col_o(v_col), .h_row_o(h_row), .v_back_o(v_back), .h_back_o(h_back),
    .relocate_o(reloc), .sweep_done_o(sweep), .busy_o(busy)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_step();
    bit turned;
    exp_pos = exp_back ? exp_pos - 2 : exp_pos + 2;
    turned = exp_back ? (exp_pos == 0) : (exp_pos == N - 2);
    if (turned) exp_back = ~exp_back;
    return turned;
  endfunction

  // entered and left on a falling edge
  task automatic do_step(bit sk, int hold);
    bit turned;
    run = 1'b1; skip = sk;
    @(negedge clk);
    run = 1'b0; skip = 1'b0;
    turned = model_step();
    chk("R2 v_col", int'(v_col), exp_pos);
    chk("R2 h_row", int'(h_row), exp_pos);
    chk("R6 back", int'(v_back), int'(exp_back));
    chk("R7 sweep", int'(sweep), int'(turned));
    chk("R9 even", int'(v_col[0]), 0);
    if (sk) begin
      chk("R8 no relocate", int'(reloc), 0);
      chk("R8 idle", int'(busy), 0);
    end else begin
      chk("R3 relocate", int'(reloc), 1);
      run = 1'b1;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk("R3 one cycle", int'(reloc), 0);
        chk("R4 frozen", int'(v_col), exp_pos);
        chk("R4 busy", int'(busy), 1);
      end
      run = 1'b0; ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      chk("R4 released", int'(busy), 0);
      chk("R4 no move on ack", int'(v_col), exp_pos);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 v_col", int'(v_col), 0);
    chk("R1 h_row", int'(h_row), 0);
    chk("R1 back", int'(v_back) + int'(h_back), 0);
    chk("R1 strobes", int'(reloc) + int'(sweep) + int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 ack while idle
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R5 pos", int'(v_col), 0);
    chk("R5 relocate", int'(reloc), 0);
    chk("R5 busy", int'(busy), 0);
    // R10 full round trip
    for (int s = 0; s < N - 2; s++) do_step(1'b0, 0);
    chk("R10 home", int'(v_col), 0);
    chk("R10 forward", int'(v_back), 0);
    // R8 back-to-back skips
    do_step(1'b1, 0);
    do_step(1'b1, 0);
    do_step(1'b0, 2);
    // random mix
    for (int s = 0; s < 60; s++) begin
      do_step(($urandom % 4) == 0, $urandom % 4);
      if (($urandom % 3) == 0) begin
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R5 idle ack", int'(v_col), exp_pos);
        chk("R5 idle busy", int'(busy), 0);
      end
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule